// File: doc/BRIEF.md
# Multi-subdomain clock enable generator

This block produces single-cycle clock-enable pulses for five clocked subdomains: the processor core, the memory-management unit (MMU), the external peripherals, the watchdog and the internal timers. All logic runs on one fast clock `clk`. A reference tick `ref_tick` marks each period of the slower reference clock. The enables are meant to qualify flops in each subdomain, so no real clock gating or clock muxing happens here.

A single control word is loaded through a write strobe. It selects a power-of-two divide ratio for the core, MMU and peripheral enables, the on/off gates, the peripheral and timer sources, and a bypass bit. While bypass is set, the source tick equals the reference tick, which is the reset condition. With bypass clear, the source ticks on every `clk` cycle.

A 3-bit phase counter advances on source ticks and is shared by all divided enables, so these enables stay phase-aligned. A newly written word is first held as programmed state. It becomes effective only at the end of an 8-tick frame. A frame end is a terminal count for every ratio, so a new setting never shortens or stretches a pulse period. An error flag reports an illegal core-to-MMU ratio.

Top module: `clkdom_enable_gen`

## Requirements
- R1: After reset the control word is bypass=1 with every other field 0: all divides are 1, MMU and peripheral enables are off, and the timer uses source/2. `ratio_err` is 0.
- R2: The source tick is `ref_tick` while the effective bypass bit is 1, and every `clk` cycle while it is 0.
- R3: `core_en` is high on a source tick whose phase count (0 to 7, counting source ticks since reset) is a multiple of 2^core_div. The field `core_div` is `wr_data[1:0]`.
- R4: `mmu_en` is high on a source tick whose phase count is a multiple of 2^mmu_div, and only while `mmu_on` is 1. The field `mmu_div` is `wr_data[3:2]` and `mmu_on` is `wr_data[4]`.
- R5: `ratio_err` is high while the programmed `mmu_div` is neither equal to `core_div` nor `core_div`+1. While the effective fields break this rule, `mmu_en` uses the `core_div` pattern.
- R6: A written word is held as programmed state; `ratio_err` follows it from the next cycle. It becomes effective for all enables and for bypass only in the cycle after the source tick at phase count 7.
- R7: `per_en` is low while `per_on` (`wr_data[7]`) is 0. When `per_ref` (`wr_data[8]`) is 1, `per_en` equals `ref_tick`. Otherwise it pulses on source ticks at phase multiples of 2^per_div (`wr_data[6:5]`).
- R8: `wdt_en` is high on every 14th `ref_tick`, starting with the first after reset, regardless of bypass.
- R9: When `tim_ref` (`wr_data[9]`) is 1, `tim_en` equals `ref_tick`. Otherwise `tim_en` is high on source ticks at even phase counts. Bypass is `wr_data[10]`.
- R10: Every `mmu_en` pulse coincides with a `core_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 11 | Control word (field layout in R3 to R9) |
| core_en | output | 1 | Core subdomain enable |
| mmu_en | output | 1 | MMU subdomain enable |
| per_en | output | 1 | External peripheral enable |
| wdt_en | output | 1 | Watchdog enable (reference / 14) |
| tim_en | output | 1 | Internal timer enable |
| ratio_err | output | 1 | Programmed core/MMU ratio is illegal |

## Verification
The hardest situation to reach is a word written in the middle of a frame while bypass is set. Source ticks then come only with sparse reference ticks, so the old setting must be seen to persist for an unpredictable number of cycles. The bench holds `ref_tick` random in several phases and issues writes at random cycle gaps. Some of these writes switch bypass itself or program illegal core/MMU pairs. A behavioural model recomputes every enable on every cycle, so each deferred switch, and each fallback of the MMU pattern to the core pattern, is compared as it happens.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;

   localparam int DIV_W = 2;                  // log2 divide field width
   localparam int PH_W  = (1 << DIV_W) - 1;   // phase bits: largest ratio 2^PH_W

   typedef struct packed {
      logic             bypass;    // [10]
      logic             tim_ref;   // [9]
      logic             per_ref;   // [8]
      logic             per_on;    // [7]
      logic [DIV_W-1:0] per_div;   // [6:5]
      logic             mmu_on;    // [4]
      logic [DIV_W-1:0] mmu_div;   // [3:2]
      logic [DIV_W-1:0] core_div;  // [1:0]
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam ctrl_t CTRL_RST = '{bypass: 1'b1, tim_ref: 1'b0, per_ref: 1'b0,
                                  per_on: 1'b0, per_div: '0, mmu_on: 1'b0,
                                  mmu_div: '0, core_div: '0};

   // low d bits set: phase must be zero there for a 2^d pulse
   function automatic logic [PH_W-1:0] div_mask(input logic [DIV_W-1:0] d);
      logic [PH_W-1:0] m;
      m = '0;
      for (int i = 0; i < PH_W; i++) m[i] = (i < int'(d));
      return m;
   endfunction

   // MMU rate equal to core rate or one half of it
   function automatic logic ratio_ok(input logic [DIV_W-1:0] core,
                                     input logic [DIV_W-1:0] mmu);
      return (mmu == core) ||
             ({1'b0, mmu} == ({1'b0, core} + (DIV_W+1)'(1)));
   endfunction

endpackage

// File: rtl/clkdom_phase.sv
module clkdom_phase
   import clkdom_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            src_tick,
   output logic [PH_W-1:0] phase,
   output logic            frame_end
);

   logic [PH_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (src_tick) cnt_q <= cnt_q + 1'b1;
   end

   assign phase     = cnt_q;
   assign frame_end = src_tick && (&cnt_q);

endmodule

// File: rtl/clkdom_ratio_tap.sv
module clkdom_ratio_tap
   import clkdom_pkg::*;
(
   input  logic             src_tick,
   input  logic [PH_W-1:0]  phase,
   input  logic [DIV_W-1:0] div,
   output logic             pulse
);

   assign pulse = src_tick && ((phase & div_mask(div)) == '0);

endmodule

// File: rtl/clkdom_ref_div.sv
module clkdom_ref_div #(
   parameter int N = 14
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ref_tick,
   output logic pulse
);

   localparam int CW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 2) begin : g_bad_n
         $error("clkdom_ref_div: N must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ref_tick)
         cnt_q <= (cnt_q == CW'(N - 1)) ? '0 : cnt_q + 1'b1;
   end

   assign pulse = ref_tick && (cnt_q == '0);

endmodule

// File: rtl/clkdom_enable_gen.sv
module clkdom_enable_gen
   import clkdom_pkg::*;
#(
   parameter int WDT_DIV = 14
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   output logic              core_en,
   output logic              mmu_en,
   output logic              per_en,
   output logic              wdt_en,
   output logic              tim_en,
   output logic              ratio_err
);

   localparam int NTAP    = 4;   // core, mmu, peripheral, timer
   localparam int TAP_CORE = 0;
   localparam int TAP_MMU  = 1;
   localparam int TAP_PER  = 2;
   localparam int TAP_TIM  = 3;

   generate
      if (WDT_DIV < 2) begin : g_bad_wdt
         $error("clkdom_enable_gen: WDT_DIV must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   ctrl_t            eff_q;
   logic             src_tick;
   logic             frame_end;
   logic [PH_W-1:0]  phase;
   logic             mmu_ok;
   logic [DIV_W-1:0] tap_div [NTAP];
   logic [NTAP-1:0]  tap_hit;

   // programmed word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_q <= CTRL_RST;
      else if (wr_en) ctrl_q <= ctrl_t'(wr_data);
   end

   // effective word, swapped only on a frame boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         eff_q <= CTRL_RST;
      else if (frame_end) eff_q <= ctrl_q;
   end

   assign src_tick = eff_q.bypass ? ref_tick : 1'b1;

   clkdom_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_tick  (src_tick),
      .phase     (phase),
      .frame_end (frame_end)
   );

   assign mmu_ok = ratio_ok(eff_q.core_div, eff_q.mmu_div);

   always_comb begin
      tap_div[TAP_CORE] = eff_q.core_div;
      tap_div[TAP_MMU]  = mmu_ok ? eff_q.mmu_div : eff_q.core_div;
      tap_div[TAP_PER]  = eff_q.per_div;
      tap_div[TAP_TIM]  = DIV_W'(1);
   end

   generate
      for (genvar g = 0; g < NTAP; g++) begin : g_tap
         clkdom_ratio_tap u_tap (
            .src_tick (src_tick),
            .phase    (phase),
            .div      (tap_div[g]),
            .pulse    (tap_hit[g])
         );
      end
   endgenerate

   clkdom_ref_div #(.N(WDT_DIV)) u_wdt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .pulse    (wdt_en)
   );

   assign core_en   = tap_hit[TAP_CORE];
   assign mmu_en    = eff_q.mmu_on && tap_hit[TAP_MMU];
   assign per_en    = eff_q.per_on && (eff_q.per_ref ? ref_tick : tap_hit[TAP_PER]);
   assign tim_en    = eff_q.tim_ref ? ref_tick : tap_hit[TAP_TIM];
   assign ratio_err = !ratio_ok(ctrl_q.core_div, ctrl_q.mmu_div);

endmodule

// File: rtl/clkdom_enable_gen_chk.sv
module clkdom_enable_gen_chk
   import clkdom_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ref_tick,
   input logic              core_en,
   input logic              mmu_en,
   input logic              per_en,
   input logic              wdt_en,
   input logic              tim_en,
   input logic              byp,
   input logic              frame_end,
   input logic [CTRL_W-1:0] eff_word
);

   // mmu pulses only ever land on core pulses
   assert_mmu_on_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mmu_en |-> core_en);

   // watchdog only moves with the reference
   assert_wdt_on_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_en |-> ref_tick);

   // in bypass, core pulses need a reference tick
   assert_core_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |-> (ref_tick || !byp));

   // timer and peripheral likewise follow source or reference ticks
   assert_tim_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tim_en |-> (ref_tick || !byp));

   assert_per_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      per_en |-> (ref_tick || !byp));

   // effective settings change only after a frame end
   assert_frame_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(eff_word) |-> $past(frame_end));

endmodule

bind clkdom_enable_gen clkdom_enable_gen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_tick  (ref_tick),
   .core_en   (core_en),
   .mmu_en    (mmu_en),
   .per_en    (per_en),
   .wdt_en    (wdt_en),
   .tim_en    (tim_en),
   .byp       (eff_q.bypass),
   .frame_end (frame_end),
   .eff_word  (eff_q)
);

// File: tb/clkdom_enable_gen_tb.sv
module clkdom_enable_gen_tb;
   import clkdom_pkg::*;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_tick = 1'b0;
   logic              wr_en = 1'b0;
   logic [CTRL_W-1:0] wr_data = '0;
   logic core_en, mmu_en, per_en, wdt_en, tim_en, ratio_err;

   always #10 clk = ~clk;   // 50 MHz

   clkdom_enable_gen u_dut (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
      .wr_data(wr_data), .core_en(core_en), .mmu_en(mmu_en), .per_en(per_en),
      .wdt_en(wdt_en), .tim_en(tim_en), .ratio_err(ratio_err)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;
   bit first = 0;

   // model state
   int m_ph, m_wc;
   int p_core, p_mmu, p_per;  bit p_mon, p_pon, p_pref, p_tref, p_byp;  // programmed
   int e_core, e_mmu, e_per;  bit e_mon, e_pon, e_pref, e_tref, e_byp;  // effective

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit legal(input int c, input int m);
      return (m == c) || (m == c + 1);
   endfunction

   function automatic bit on_mult(input int ph, input int d);
      return (ph % (1 << d)) == 0;
   endfunction

   function automatic logic [CTRL_W-1:0] word(input int core, input int mmu, input bit mon,
                                               input int per, input bit pon, input bit pref,
                                               input bit tref, input bit byp);
      logic [CTRL_W-1:0] w;
      w = '0;
      w[1:0] = core[1:0];  w[3:2] = mmu[1:0];  w[4] = mon;
      w[6:5] = per[1:0];   w[7] = pon;  w[8] = pref;  w[9] = tref;  w[10] = byp;
      return w;
   endfunction

   task automatic model_reset();
      m_ph = 0; m_wc = 0;
      p_core = 0; p_mmu = 0; p_per = 0; p_mon = 0; p_pon = 0; p_pref = 0; p_tref = 0; p_byp = 1;
      e_core = 0; e_mmu = 0; e_per = 0; e_mon = 0; e_pon = 0; e_pref = 0; e_tref = 0; e_byp = 1;
   endtask

   task automatic compare(input bit rt);
      bit tick, x_core, x_mmu, x_per, x_wdt, x_tim, x_err;
      int md;
      tick   = e_byp ? rt : 1'b1;
      x_core = tick && on_mult(m_ph, e_core);
      md     = legal(e_core, e_mmu) ? e_mmu : e_core;
      x_mmu  = e_mon && tick && on_mult(m_ph, md);
      x_per  = e_pon && (e_pref ? rt : (tick && on_mult(m_ph, e_per)));
      x_wdt  = rt && (m_wc == 0);
      x_tim  = e_tref ? rt : (tick && on_mult(m_ph, 1));
      x_err  = !legal(p_core, p_mmu);
      if (first) begin
         chk("R1 mmu_en off after reset", mmu_en, 1'b0);
         chk("R1 per_en off after reset", per_en, 1'b0);
         chk("R1 ratio_err clear after reset", ratio_err, 1'b0);
         chk("R1 core_en follows ref in bypass", core_en, rt);
         first = 0;
      end
      chk("R2 R3 R6 core_en", core_en, x_core);
      chk("R4 R5 mmu_en", mmu_en, x_mmu);
      chk("R7 per_en", per_en, x_per);
      chk("R8 wdt_en", wdt_en, x_wdt);
      chk("R9 tim_en", tim_en, x_tim);
      chk("R5 ratio_err", ratio_err, x_err);
      chk("R10 mmu_en without core_en", mmu_en && !core_en, 1'b0);
   endtask

   task automatic advance(input bit rt, input bit we, input logic [CTRL_W-1:0] wd);
      bit tick;
      tick = e_byp ? rt : 1'b1;
      if (tick) begin
         if (m_ph == 7) begin
            e_core = p_core; e_mmu = p_mmu; e_per = p_per; e_mon = p_mon;
            e_pon = p_pon; e_pref = p_pref; e_tref = p_tref; e_byp = p_byp;
         end
         m_ph = (m_ph + 1) % 8;
      end
      if (rt) m_wc = (m_wc + 1) % 14;
      if (we) begin
         p_core = int'(wd[1:0]); p_mmu = int'(wd[3:2]); p_mon = wd[4];
         p_per = int'(wd[6:5]); p_pon = wd[7]; p_pref = wd[8]; p_tref = wd[9]; p_byp = wd[10];
      end
   endtask

   task automatic cyc(input bit rt, input bit we, input logic [CTRL_W-1:0] wd);
      @(negedge clk);
      ref_tick = rt; wr_en = we; wr_data = wd;
      #5;
      compare(rt);
      @(posedge clk);
      #1;
      advance(rt, we, wd);
   endtask

   // mode 0: ref every cycle, 1: ref every third cycle, 2: random ref
   task automatic run(input int n, input int mode);
      for (int i = 0; i < n; i++) begin
         bit rt;
         case (mode)
            0:       rt = 1'b1;
            1:       rt = (i % 3) == 0;
            default: rt = ($urandom_range(0, 2) == 0);
         endcase
         cyc(rt, 1'b0, '0);
      end
   endtask

   task automatic wr(input logic [CTRL_W-1:0] w, input int mode);
      bit rt;
      rt = (mode == 0) ? 1'b1 : ($urandom_range(0, 1) == 0);
      cyc(rt, 1'b1, w);
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      first = 1;
      // R1 R2 R8: reset defaults in bypass with a slow reference
      run(60, 1);
      run(40, 2);
      // R2: leave bypass, all ratios 1 (R6: applied at frame end)
      wr(word(0, 0, 1, 0, 1, 0, 0, 0), 2);
      run(30, 2);
      // R3 R4 R7 legal half-rate MMU, slow peripheral
      wr(word(1, 2, 1, 3, 1, 0, 0, 0), 0);
      run(40, 0);
      // R5 illegal pair: error and fallback
      wr(word(0, 3, 1, 2, 1, 0, 0, 0), 0);
      run(30, 2);
      wr(word(2, 1, 1, 2, 1, 0, 0, 0), 0);
      run(30, 2);
      // R7 R9 reference-sourced peripheral and timer
      wr(word(3, 3, 1, 1, 1, 1, 1, 0), 0);
      run(40, 2);
      wr(word(2, 3, 1, 0, 0, 1, 0, 0), 0);
      run(30, 2);
      // R2 R6 back into bypass with a random reference
      wr(word(1, 1, 1, 1, 1, 0, 0, 1), 0);
      run(80, 2);
      // R6 random mid-frame writes in both bypass states
      for (int k = 0; k < 30; k++) begin
         wr(word($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 3), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))), 2);
         run($urandom_range(3, 20), 2);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule